// File: doc/BRIEF.md
# Registering Clock Driver Control Word Sequencer

This block programs the control words of a DDR4 registering clock driver after the DRAM contents have been brought back. A single start pulse launches a fixed sequence of 26 control-word writes on the DRAM command bus. Every write is a one-cycle mode-register-style command to the control-word space. After each one the bus is held in deselect for a settling wait, and the length of that wait depends on the word just written. The data for each word comes from flat configuration vectors. The wait lengths in cycles are inputs. The stabilisation wait is given in microseconds and is converted to cycles inside the block, using a cycles-per-microsecond parameter.

The sequence has three phases. The first writes fourteen 4-bit words, leaving out index 7 (it shares an entry with 6) and holding back index 9. The second writes the eleven 8-bit words 1x to Bx in ascending order. The last writes the held-back 4-bit word 9 on its own. Clock enable stays high the whole time. Completion is signalled by a one-cycle done pulse.

Top module: `rcw_seq_top`

## Requirements
- R1: After reset the bus is in deselect, `cke_o` is 1, and `busy_o` and `done_o` are 0.
- R2: A start pulse sampled while idle puts the first command on the bus in the next cycle. Exactly 26 commands follow, in this order: 4-bit indices 0,1,2,3,4,5,6,8,10,11,12,13,14,15, then 8-bit indices 1 to 11, then 4-bit index 9.
- R3: A command cycle drives every `cs_n_o` bit low, `act_n_o` high, `ras_n_o`/`cas_n_o`/`we_n_o` low, `bg_o`=2'b01 and `ba_o`=2'b11.
- R4: A 4-bit word drives its index on `addr_o[7:4]` and its data on `addr_o[3:0]`, with all other address bits 0. The data for index i is `cfg_rc4_i[4i+3:4i]`.
- R5: An 8-bit word n drives n on `addr_o[11:8]` and its data on `addr_o[7:0]`, with all other address bits 0. The data for word n is `cfg_rc8_i[8n-1:8n-8]`.
- R6: After a 4-bit word in the first phase, the bus stays in deselect for exactly W cycles before the next command. W is `wait_mrd_i` after 0,1,8,12,14; `wait_mrd_l_i` after 3,4,5,11; `wait_mrd_l2_i` after 13,15; `wait_mrc1_i` after 6; and the stabilisation wait after 2 and 10.
- R7: After 8-bit words the wait is `wait_mrd_l_i` for 7x and Bx, the stabilisation wait for 3x, and `wait_mrd_i` for all others. After the final word 9 the wait is `wait_mrd_i`.
- R8: The stabilisation wait is `stab_us_i` × CYC_PER_US cycles.
- R9: A wait value that works out to 0 is treated as 1, so two commands never fall in adjacent cycles.
- R10: Every non-command cycle is a deselect: all `cs_n_o` high, `act_n_o`/`ras_n_o`/`cas_n_o`/`we_n_o` high, and `bg_o`, `ba_o` and `addr_o` all 0.
- R11: `done_o` is high for exactly one cycle, the cycle after the last wait ends. `busy_o` is high from the first command cycle through the last wait cycle, and is low while `done_o` is high.
- R12: A start pulse while `busy_o` is high is ignored. The sequence runs on unchanged.
- R13: `cke_o` is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| cfg_rc4_i | input | 64 | 4-bit word data, one nibble per index |
| cfg_rc8_i | input | 88 | 8-bit word data for words 1x to Bx |
| wait_mrd_i | input | WAIT_W | Short command-to-command wait, cycles |
| wait_mrd_l_i | input | WAIT_W | Long command-to-command wait, cycles |
| wait_mrd_l2_i | input | WAIT_W | Second long wait, cycles |
| wait_mrc1_i | input | WAIT_W | Wait after the combined word 6/7, cycles |
| stab_us_i | input | STAB_US_W | Stabilisation wait, microseconds |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cke_o | output | 1 | Clock enable |
| cs_n_o | output | CS_W | Chip selects, active low |
| act_n_o | output | 1 | Activate, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| bg_o | output | 2 | Bank group |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Address bus |

## Verification
The properties assume that the configuration and wait inputs are held steady while a sequence runs. They also assume `start_i` is a clean synchronous level, because the spacing the block produces is only meaningful against fixed wait values. The stimulus meets these assumptions: it loads a fresh configuration only between runs, and a reset is issued before the first run.

The only input that changes mid-run is a deliberate start pulse inside one sequence. That pulse exercises the ignore rule without disturbing anything else.

// File: rtl/rcw_seq_pkg.sv
package rcw_seq_pkg;

  localparam int unsigned N_NARROW = 14;
  localparam int unsigned N_WIDE   = 11;
  localparam int unsigned N_STEPS  = N_NARROW + N_WIDE + 1;
  localparam int unsigned STEP_W   = $clog2(N_STEPS);
  localparam int unsigned RC4_BITS = 16 * 4;
  localparam int unsigned RC8_BITS = N_WIDE * 8;

  typedef enum logic [2:0] {
    WC_SHORT,
    WC_LONG,
    WC_LONG2,
    WC_PAIR,
    WC_SETTLE
  } wclass_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FIN
  } seq_state_e;

  typedef struct packed {
    logic    wide;
    logic [3:0] idx;
    wclass_e cls;
  } rcw_step_t;

  // Position in the walk -> word kind, index and settling class.
  function automatic rcw_step_t step_info(input int s);
    rcw_step_t r;
    int        i;
    r.wide = 1'b0;
    if (s < int'(N_NARROW)) begin
      if (s < 7)       i = s;
      else if (s == 7) i = 8;
      else             i = s + 2;
    end else if (s < int'(N_NARROW + N_WIDE)) begin
      r.wide = 1'b1;
      i      = s - int'(N_NARROW) + 1;
    end else begin
      i = 9;
    end
    r.idx = 4'(i);
    if (r.wide) begin
      case (i)
        3:       r.cls = WC_SETTLE;
        7, 11:   r.cls = WC_LONG;
        default: r.cls = WC_SHORT;
      endcase
    end else begin
      case (i)
        2, 10:      r.cls = WC_SETTLE;
        3, 4, 5, 11: r.cls = WC_LONG;
        13, 15:     r.cls = WC_LONG2;
        6:          r.cls = WC_PAIR;
        default:    r.cls = WC_SHORT;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/rcw_step_decode.sv
module rcw_step_decode
  import rcw_seq_pkg::*;
#(
  parameter int unsigned WAIT_W     = 8,
  parameter int unsigned STAB_US_W  = 8,
  parameter int unsigned CYC_PER_US = 1600,
  parameter int unsigned STAB_W     = 19,
  parameter int unsigned CNT_W      = 19
) (
  input  logic [STEP_W-1:0]    step_i,
  input  logic [RC4_BITS-1:0]  cfg_rc4_i,
  input  logic [RC8_BITS-1:0]  cfg_rc8_i,
  input  logic [WAIT_W-1:0]    wait_mrd_i,
  input  logic [WAIT_W-1:0]    wait_mrd_l_i,
  input  logic [WAIT_W-1:0]    wait_mrd_l2_i,
  input  logic [WAIT_W-1:0]    wait_mrc1_i,
  input  logic [STAB_US_W-1:0] stab_us_i,
  output logic                 wide_o,
  output logic [3:0]           idx_o,
  output logic [7:0]           data_o,
  output logic [CNT_W-1:0]     wait_o
);

  localparam int unsigned EXT8_W = 16 * 8;
  localparam int unsigned PAD8   = EXT8_W - RC8_BITS - 8;

  rcw_step_t          info;
  logic [EXT8_W-1:0]  ext8;
  logic [STAB_W-1:0]  stab_cyc;
  logic [CNT_W-1:0]   raw;

  assign info     = step_info(int'(step_i));
  assign ext8     = {{PAD8{1'b0}}, cfg_rc8_i, 8'h00};
  assign stab_cyc = STAB_W'(stab_us_i) * STAB_W'(CYC_PER_US);

  assign wide_o = info.wide;
  assign idx_o  = info.idx;

  always_comb begin
    if (info.wide) data_o = ext8[{info.idx, 3'b000} +: 8];
    else           data_o = {4'h0, cfg_rc4_i[{info.idx, 2'b00} +: 4]};
  end

  always_comb begin
    unique case (info.cls)
      WC_SHORT:  raw = CNT_W'(wait_mrd_i);
      WC_LONG:   raw = CNT_W'(wait_mrd_l_i);
      WC_LONG2:  raw = CNT_W'(wait_mrd_l2_i);
      WC_PAIR:   raw = CNT_W'(wait_mrc1_i);
      WC_SETTLE: raw = CNT_W'(stab_cyc);
      default:   raw = CNT_W'(wait_mrd_i);
    endcase
    wait_o = (raw == '0) ? CNT_W'(1) : raw;
  end

endmodule

// File: rtl/rcw_wait_timer.sv
module rcw_wait_timer #(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             tick_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | tick_i;

  always_comb begin
    if (load_i) cnt_d = val_i - CNT_W'(1);
    else        cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/rcw_cmd_encode.sv
module rcw_cmd_encode #(
  parameter int unsigned CS_W   = 2,
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic              wide_i,
  input  logic [3:0]        idx_i,
  input  logic [7:0]        data_i,
  output logic              cke_o,
  output logic [CS_W-1:0]   cs_n_o,
  output logic              act_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [1:0]        bg_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [1:0] CW_BG = 2'b01;
  localparam logic [1:0] CW_BA = 2'b11;

  logic [CS_W-1:0]   cs_n_d;
  logic              strb_n_d;
  logic [1:0]        bg_d, ba_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    cs_n_d   = '1;
    strb_n_d = 1'b1;
    bg_d     = 2'b00;
    ba_d     = 2'b00;
    addr_d   = '0;
    if (issue_i) begin
      cs_n_d   = '0;
      strb_n_d = 1'b0;
      bg_d     = CW_BG;
      ba_d     = CW_BA;
      if (wide_i) begin
        addr_d[11:8] = idx_i;
        addr_d[7:0]  = data_i;
      end else begin
        addr_d[7:4]  = idx_i;
        addr_d[3:0]  = data_i[3:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_o   <= 1'b1;
      cs_n_o  <= '1;
      act_n_o <= 1'b1;
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
      we_n_o  <= 1'b1;
      bg_o    <= 2'b00;
      ba_o    <= 2'b00;
      addr_o  <= '0;
    end else begin
      cke_o   <= 1'b1;
      cs_n_o  <= cs_n_d;
      act_n_o <= 1'b1;
      ras_n_o <= strb_n_d;
      cas_n_o <= strb_n_d;
      we_n_o  <= strb_n_d;
      bg_o    <= bg_d;
      ba_o    <= ba_d;
      addr_o  <= addr_d;
    end
  end

endmodule

// File: rtl/rcw_seq_top.sv
module rcw_seq_top
  import rcw_seq_pkg::*;
#(
  parameter int unsigned CS_W       = 2,
  parameter int unsigned ADDR_W     = 14,
  parameter int unsigned WAIT_W     = 8,
  parameter int unsigned STAB_US_W  = 8,
  parameter int unsigned CYC_PER_US = 1600
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [RC4_BITS-1:0]  cfg_rc4_i,
  input  logic [RC8_BITS-1:0]  cfg_rc8_i,
  input  logic [WAIT_W-1:0]    wait_mrd_i,
  input  logic [WAIT_W-1:0]    wait_mrd_l_i,
  input  logic [WAIT_W-1:0]    wait_mrd_l2_i,
  input  logic [WAIT_W-1:0]    wait_mrc1_i,
  input  logic [STAB_US_W-1:0] stab_us_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 cke_o,
  output logic [CS_W-1:0]      cs_n_o,
  output logic                 act_n_o,
  output logic                 ras_n_o,
  output logic                 cas_n_o,
  output logic                 we_n_o,
  output logic [1:0]           bg_o,
  output logic [1:0]           ba_o,
  output logic [ADDR_W-1:0]    addr_o
);

  localparam int unsigned STAB_W = STAB_US_W + $clog2(CYC_PER_US + 1);
  localparam int unsigned CNT_W  = (STAB_W > WAIT_W) ? STAB_W : WAIT_W;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  seq_state_e        st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;
  logic              tmr_load, tmr_tick, tmr_expired;
  logic              word_wide;
  logic [3:0]        word_idx;
  logic [7:0]        word_data;
  logic [CNT_W-1:0]  word_wait;

  always_comb begin
    st_d     = st_q;
    step_d   = step_q;
    step_en  = 1'b0;
    tmr_load = 1'b0;
    tmr_tick = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_FIN: begin
        if (start_i) begin
          st_d    = ST_ISSUE;
          step_d  = '0;
          step_en = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_ISSUE: begin
        st_d     = ST_WAIT;
        tmr_load = 1'b1;
      end
      ST_WAIT: begin
        if (tmr_expired) begin
          if (step_q == LAST_STEP) begin
            st_d = ST_FIN;
          end else begin
            st_d    = ST_ISSUE;
            step_d  = step_q + STEP_W'(1);
            step_en = 1'b1;
          end
        end else begin
          tmr_tick = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  rcw_step_decode #(
    .WAIT_W     (WAIT_W),
    .STAB_US_W  (STAB_US_W),
    .CYC_PER_US (CYC_PER_US),
    .STAB_W     (STAB_W),
    .CNT_W      (CNT_W)
  ) u_dec (
    .step_i        (step_d),
    .cfg_rc4_i     (cfg_rc4_i),
    .cfg_rc8_i     (cfg_rc8_i),
    .wait_mrd_i    (wait_mrd_i),
    .wait_mrd_l_i  (wait_mrd_l_i),
    .wait_mrd_l2_i (wait_mrd_l2_i),
    .wait_mrc1_i   (wait_mrc1_i),
    .stab_us_i     (stab_us_i),
    .wide_o        (word_wide),
    .idx_o         (word_idx),
    .data_o        (word_data),
    .wait_o        (word_wait)
  );

  rcw_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk       (clk),
    .rst_n     (srst_n),
    .load_i    (tmr_load),
    .val_i     (word_wait),
    .tick_i    (tmr_tick),
    .expired_o (tmr_expired)
  );

  rcw_cmd_encode #(.CS_W(CS_W), .ADDR_W(ADDR_W)) u_enc (
    .clk     (clk),
    .rst_n   (srst_n),
    .issue_i (st_d == ST_ISSUE),
    .wide_i  (word_wide),
    .idx_i   (word_idx),
    .data_i  (word_data),
    .cke_o   (cke_o),
    .cs_n_o  (cs_n_o),
    .act_n_o (act_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .bg_o    (bg_o),
    .ba_o    (ba_o),
    .addr_o  (addr_o)
  );

  assign busy_o = (st_q == ST_ISSUE) || (st_q == ST_WAIT);
  assign done_o = (st_q == ST_FIN);

endmodule

// File: rtl/rcw_seq_chk.sv
module rcw_seq_chk #(
  parameter int unsigned CS_W   = 2,
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              cke_o,
  input logic [CS_W-1:0]   cs_n_o,
  input logic              act_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [1:0]        bg_o,
  input logic [1:0]        ba_o,
  input logic [ADDR_W-1:0] addr_o
);

  logic cmd;
  assign cmd = (cs_n_o != '1);

  assert_cke_high_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cke_o);

  assert_cmd_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |-> (cs_n_o == '0) && act_n_o && !ras_n_o && !cas_n_o && !we_n_o
            && (bg_o == 2'b01) && (ba_o == 2'b11));

  assert_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd |-> act_n_o && ras_n_o && cas_n_o && we_n_o
             && (bg_o == 2'b00) && (ba_o == 2'b00) && (addr_o == '0));

  assert_no_adjacent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |=> !cmd);

  assert_cmd_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |-> busy_o);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !cmd);

  assert_busy_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o));

endmodule

bind rcw_seq_top rcw_seq_chk #(.CS_W(CS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .cke_o   (cke_o),
  .cs_n_o  (cs_n_o),
  .act_n_o (act_n_o),
  .ras_n_o (ras_n_o),
  .cas_n_o (cas_n_o),
  .we_n_o  (we_n_o),
  .bg_o    (bg_o),
  .ba_o    (ba_o),
  .addr_o  (addr_o)
);

// File: tb/sim_rcw_seq_top.sv
`timescale 1ns/1ps
module sim_rcw_seq_top;

  localparam int CPU    = 4;
  localparam int CS_W   = 2;
  localparam int ADDR_W = 14;
  localparam int NST    = 26;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [63:0] cfg4;
  logic [87:0] cfg8;
  logic [7:0]  w_mrd, w_l, w_l2, w_pair, stab;
  logic        busy, done, cke, act_n, ras_n, cas_n, we_n;
  logic [CS_W-1:0]   cs_n;
  logic [1:0]        bg, ba;
  logic [ADDR_W-1:0] addr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit mon_on = 0;
  bit ended  = 0;
  int ncmd, done_cnt, done_cyc, busy_cnt;
  int cmd_cyc [32];
  int cmd_addr[32];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rcw_seq_top #(.CS_W(CS_W), .ADDR_W(ADDR_W), .WAIT_W(8), .STAB_US_W(8),
                .CYC_PER_US(CPU)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_rc4_i(cfg4), .cfg_rc8_i(cfg8),
    .wait_mrd_i(w_mrd), .wait_mrd_l_i(w_l), .wait_mrd_l2_i(w_l2),
    .wait_mrc1_i(w_pair), .stab_us_i(stab), .busy_o(busy), .done_o(done),
    .cke_o(cke), .cs_n_o(cs_n), .act_n_o(act_n), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .bg_o(bg), .ba_o(ba), .addr_o(addr));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (cs_n != '1) begin
        if (ncmd < 32) begin
          cmd_cyc[ncmd]  = cyc;
          cmd_addr[ncmd] = int'(addr);
        end
        ncmd++;
        check(cs_n == '0 && act_n && !ras_n && !cas_n && !we_n && bg == 2'b01
              && ba == 2'b11, "R3 command shape", int'({bg, ba}), 7);
      end else begin
        check(act_n && ras_n && cas_n && we_n && bg == 0 && ba == 0 && addr == 0,
              "R10 deselect", int'(addr), 0);
      end
      check(cke == 1'b1, "R13 cke", int'(cke), 1);
      if (busy) busy_cnt++;
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
    end
  end

  function automatic int exp_idx(input int s);
    if (s < 14) return (s < 7) ? s : ((s == 7) ? 8 : s + 2);
    if (s < 25) return s - 13;
    return 9;
  endfunction

  function automatic bit exp_wide(input int s);
    return (s >= 14) && (s < 25);
  endfunction

  // 0 short, 1 long, 2 long2, 3 pair, 4 settle
  function automatic int exp_cls(input int s);
    int i = exp_idx(s);
    if (exp_wide(s)) return (i == 3) ? 4 : ((i == 7 || i == 11) ? 1 : 0);
    case (i)
      2, 10: return 4;
      3, 4, 5, 11: return 1;
      13, 15: return 2;
      6: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int raw_wait(input int s);
    case (exp_cls(s))
      1: return int'(w_l);
      2: return int'(w_l2);
      3: return int'(w_pair);
      4: return int'(stab) * CPU;
      default: return int'(w_mrd);
    endcase
  endfunction

  function automatic int exp_wait(input int s);
    int r = raw_wait(s);
    return (r == 0) ? 1 : r;
  endfunction

  function automatic int exp_addr(input int s);
    int i = exp_idx(s);
    if (exp_wide(s)) return (i << 8) | int'(cfg8[8*(i-1) +: 8]);
    return (i << 4) | int'(cfg4[4*i +: 4]);
  endfunction

  function automatic string gap_req(input int s);
    if (exp_cls(s) == 4) return "R8 settle wait";
    if (raw_wait(s) == 0) return "R9 zero wait";
    if (exp_wide(s) || s == 25) return "R7 wait class";
    return "R6 wait class";
  endfunction

  task automatic run_case(input int r);
    int s0;
    int glitch = (r == 3) ? 40 : -1;
    for (int i = 0; i < 16; i++) cfg4[4*i +: 4] = 4'((i * 5 + r * 3) & 15);
    for (int i = 0; i < 11; i++) cfg8[8*i +: 8] = 8'(((i + 1) * 37 + r * 91) & 255);
    w_mrd  = 8'(r % 3);
    w_l    = 8'(r + 1);
    w_l2   = 8'((r * 2) % 5);
    w_pair = 8'(5 - r);
    stab   = 8'(r % 3);
    ncmd = 0; done_cnt = 0; done_cyc = -1; busy_cnt = 0;
    @(negedge clk);
    mon_on = 1;
    start  = 1'b1;
    s0     = cyc;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      start = (k == glitch);
      if (done) break;
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    mon_on = 0;
    check(ncmd == NST, "R2 command count", ncmd, NST);
    if (ncmd == NST) begin
      check(cmd_cyc[0] == s0 + 1, "R2 first command latency", cmd_cyc[0], s0 + 1);
      for (int s = 0; s < NST; s++) begin
        check(cmd_addr[s] == exp_addr(s), exp_wide(s) ? "R5 wide word" : "R4 narrow word",
              cmd_addr[s], exp_addr(s));
        if (s > 0)
          check(cmd_cyc[s] - cmd_cyc[s-1] == exp_wait(s-1) + 1, gap_req(s-1),
                cmd_cyc[s] - cmd_cyc[s-1], exp_wait(s-1) + 1);
      end
      check(done_cyc == cmd_cyc[NST-1] + exp_wait(NST-1) + 1, "R11 done timing",
            done_cyc, cmd_cyc[NST-1] + exp_wait(NST-1) + 1);
      check(busy_cnt == done_cyc - cmd_cyc[0], "R11 busy span", busy_cnt,
            done_cyc - cmd_cyc[0]);
    end
    check(done_cnt == 1, (r == 3) ? "R12 restart ignored" : "R11 done pulse",
          done_cnt, 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!ended) begin
      ended = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg4 = '0; cfg8 = '0;
    w_mrd = 1; w_l = 1; w_l2 = 1; w_pair = 1; stab = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 idle state after reset
    check(busy == 0 && done == 0, "R1 busy/done", int'({busy, done}), 0);
    check(cs_n == '1 && act_n && ras_n && cas_n && we_n && addr == 0,
          "R1 deselect", int'(addr), 0);
    check(cke == 1'b1, "R1 cke", int'(cke), 1);
    for (int r = 0; r < 6; r++) run_case(r);
    if (!ended) begin
      ended = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule